// File: doc/BRIEF.md
# Farrow Rational Sample-Rate Converter

This block resamples a real fixed-point stream by a rational factor. The factor is given as an unsigned fixed-point number with five integer bits and five fractional bits. The factor is the spacing of output samples measured in input-sample periods. Values above one decimate and values below one interpolate. Input samples enter through a valid/ready port into a shared tap window. A phase tracker works out, for each output, the input sample nearest to the ideal output instant and the signed fractional offset mu between the two.

One delay line feeds a bank of fixed FIR subfilters. Their results are combined as a polynomial in mu by Horner evaluation. The result is rounded once, saturated, and delivered on a valid/ready output together with the mu that produced it. Depending on the factor, input samples are skipped or reused. The factor is held constant between resets.

Top module: `farrow_src`

## Requirements
- R1: While rst_ni is low, out_valid_o is 0 and in_ready_o is 1.
- R2: ratio_i is unsigned, with 5 fractional bits. Output k belongs to input time t = k*ratio_i/32, in input-sample units, with input sample 0 at time 0.
- R3: The centre sample index is c = floor(t + 1/2). A tie at a half goes to the later sample. out_mu_o = (t - c)*32 as 6-bit two's complement, always within -16..15.
- R4: When ratio_i exceeds 32, input samples that are nearest to no output instant are consumed and produce no output (for example, 48 skips samples 1 and 4).
- R5: When ratio_i is below 32, one input sample serves as the centre for several consecutive outputs (for example, 20 uses sample 1 for t = 0.625 and t = 1.25).
- R6: Subfilter m forms v_m = sum over j of COEF[m][j]*x[c-2+j] (5 taps, centre at j = 2). Samples with negative index read as zero.
- R7: The output is the sum over m of v_m*mu^m*32^(3-m) (with mu in units of 1/32), plus 2^28, arithmetically shifted right by 29 and saturated to -32768..32767.
- R8: Output k is produced only after input sample c+2 has been accepted. With out_ready_i held high, out_valid_o for the first output rises on the second rising edge after the edge that accepts sample 2.
- R9: While out_valid_o is high and out_ready_i is low, out_data_o and out_mu_o hold. in_ready_o is low while an output is due, and outputs leave in order of k.
- R10: The low 5 bits of successive out_mu_o values advance by ratio_i modulo 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_i | input | 10 | Output spacing in input periods, unsigned Q5.5, nonzero |
| in_valid_i | input | 1 | Input sample offered |
| in_ready_o | output | 1 | Input sample taken on this edge when valid |
| in_data_i | input | 16 | Input sample, two's complement |
| out_valid_o | output | 1 | Output sample present |
| out_ready_i | input | 1 | Downstream takes the output sample |
| out_data_o | output | 16 | Output sample, two's complement |
| out_mu_o | output | 6 | Fractional offset of this output, signed, 1/32 units |

## Verification
Once it is due, an output passes through two registers. One holds the subfilter results and mu, and one holds the rounded sample. The first output therefore shows two rising edges after the edge that accepts its last right-hand tap. The bench records that accepting edge and checks the edge on which out_valid_o first rises against it. All other results are compared in order by a scoreboard. It pops an expected sample and mu only on cycles where the valid/ready pair completes, so stalls and skipped or reused inputs move no check to the wrong cycle.

// File: rtl/farrow_pkg.sv
package farrow_pkg;
  localparam int DEF_SUB  = 4;
  localparam int DEF_TAPS = 5;

  // Q1.14 subfilter taps, row m weights mu^m
  localparam logic signed [15:0] DEF_COEF [DEF_SUB][DEF_TAPS] = '{
    '{16'sd0,     16'sd0,     16'sd16384,  16'sd0,     16'sd0},
    '{16'sd0,    -16'sd8192,  16'sd0,      16'sd8192,  16'sd0},
    '{16'sd0,     16'sd8192, -16'sd16384,  16'sd8192,  16'sd0},
    '{-16'sd1365, 16'sd2731,  16'sd0,     -16'sd2731,  16'sd1365}
  };
endpackage

// File: rtl/frc_phase_ctrl.sv
module frc_phase_ctrl #(
  parameter int RATIO_W    = 10,
  parameter int RATIO_FRAC = 5,
  parameter int HALF       = 2,
  parameter int MU_W       = RATIO_FRAC + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               in_valid_i,
  input  logic               adv_i,
  output logic               in_ready_o,
  output logic               load_o,
  output logic               emit_o,
  output logic [MU_W-1:0]    mu_o
);
  localparam int PW = RATIO_W + 3;
  localparam logic signed [PW-1:0] ONE_Q  = PW'(1) <<< RATIO_FRAC;
  localparam logic signed [PW-1:0] HALF_Q = PW'(1) <<< (RATIO_FRAC - 1);
  localparam logic signed [PW-1:0] P_INIT = PW'(HALF + 1) <<< RATIO_FRAC;

  // p = ideal output time minus index of the window centre sample
  logic signed [PW-1:0] p_q;
  logic signed [PW-1:0] step;
  logic                 need_in;

  assign step       = {{(PW-RATIO_W){1'b0}}, ratio_i};
  assign need_in    = (p_q >= HALF_Q);
  assign in_ready_o = need_in;
  assign load_o     = need_in & in_valid_i;
  assign emit_o     = ~need_in & adv_i;
  assign mu_o       = p_q[MU_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     p_q <= P_INIT;
    else if (load_o) p_q <= p_q - ONE_Q;
    else if (emit_o) p_q <= p_q + step;
  end
endmodule

// File: rtl/frc_tap_window.sv
module frc_tap_window #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic signed [DATA_W-1:0] data_i,
  output logic signed [DATA_W-1:0] win_o [TAPS]
);
  // win_o[0] newest; reset zeros act as the leading taps
  for (genvar k = 0; k < TAPS; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     win_o[k] <= '0;
        else if (load_i) win_o[k] <= data_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     win_o[k] <= '0;
        else if (load_i) win_o[k] <= win_o[k-1];
      end
    end
  end
endmodule

// File: rtl/frc_subfilter_bank.sv
module frc_subfilter_bank #(
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 16,
  parameter int NUM_SUB = 4,
  parameter int TAPS    = 5,
  parameter int VW      = DATA_W + COEF_W + $clog2(TAPS) + 1,
  parameter logic signed [COEF_W-1:0] COEF [NUM_SUB][TAPS] = farrow_pkg::DEF_COEF
) (
  input  logic signed [DATA_W-1:0] win_i [TAPS],
  output logic signed [VW-1:0]     v_o   [NUM_SUB]
);
  for (genvar m = 0; m < NUM_SUB; m++) begin : g_sub
    logic signed [VW-1:0] sum;
    always_comb begin
      sum = '0;
      // tap j reads x[c-HALF+j], which sits at win_i[TAPS-1-j]
      for (int j = 0; j < TAPS; j++)
        sum = sum + VW'(COEF[m][j]) * VW'(win_i[TAPS-1-j]);
    end
    assign v_o[m] = sum;
  end
endmodule

// File: rtl/frc_horner.sv
module frc_horner #(
  parameter int DATA_W    = 16,
  parameter int VW        = 36,
  parameter int NUM_SUB   = 4,
  parameter int MU_W      = 6,
  parameter int MU_FRAC   = 5,
  parameter int COEF_FRAC = 14
) (
  input  logic signed [VW-1:0]     v_i [NUM_SUB],
  input  logic signed [MU_W-1:0]   mu_i,
  output logic signed [DATA_W-1:0] y_o
);
  localparam int SH    = COEF_FRAC + MU_FRAC * (NUM_SUB - 1);
  localparam int ACC_W = VW + (NUM_SUB - 1) * MU_W + 2;
  localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1) <<< (SH - 1);
  localparam logic signed [ACC_W-1:0] MAXV = (ACC_W'(1) <<< (DATA_W - 1)) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

  logic signed [ACC_W-1:0] acc, mu_ext, rnd, shr;

  always_comb begin
    mu_ext = ACC_W'(mu_i);
    acc    = ACC_W'(v_i[NUM_SUB-1]);
    // keep full precision: align each lower term to the growing scale
    for (int m = NUM_SUB - 2; m >= 0; m--)
      acc = acc * mu_ext + (ACC_W'(v_i[m]) <<< (MU_FRAC * (NUM_SUB - 1 - m)));
    rnd = acc + RND;
    shr = rnd >>> SH;
    if (shr > MAXV)      y_o = MAXV[DATA_W-1:0];
    else if (shr < MINV) y_o = MINV[DATA_W-1:0];
    else                 y_o = shr[DATA_W-1:0];
  end
endmodule

// File: rtl/farrow_src.sv
module farrow_src #(
  parameter int DATA_W     = 16,
  parameter int RATIO_INT  = 5,
  parameter int RATIO_FRAC = 5,
  parameter int COEF_W     = 16,
  parameter int COEF_FRAC  = 14,
  parameter int NUM_SUB    = farrow_pkg::DEF_SUB,
  parameter int TAPS       = farrow_pkg::DEF_TAPS,
  parameter logic signed [COEF_W-1:0] COEF [NUM_SUB][TAPS] = farrow_pkg::DEF_COEF
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [RATIO_INT+RATIO_FRAC-1:0] ratio_i,
  input  logic                            in_valid_i,
  output logic                            in_ready_o,
  input  logic signed [DATA_W-1:0]        in_data_i,
  output logic                            out_valid_o,
  input  logic                            out_ready_i,
  output logic signed [DATA_W-1:0]        out_data_o,
  output logic signed [RATIO_FRAC:0]      out_mu_o
);
  localparam int RATIO_W = RATIO_INT + RATIO_FRAC;
  localparam int HALF    = (TAPS - 1) / 2;
  localparam int MU_W    = RATIO_FRAC + 1;
  localparam int VW      = DATA_W + COEF_W + $clog2(TAPS) + 1;

  logic                     adv, load, emit;
  logic [MU_W-1:0]          mu;
  logic signed [DATA_W-1:0] win [TAPS];
  logic signed [VW-1:0]     v   [NUM_SUB];
  logic signed [VW-1:0]     s1_v [NUM_SUB];
  logic signed [MU_W-1:0]   s1_mu;
  logic                     s1_valid;
  logic signed [DATA_W-1:0] y;

  assign adv = ~out_valid_o | out_ready_i;

  frc_phase_ctrl #(
    .RATIO_W(RATIO_W), .RATIO_FRAC(RATIO_FRAC), .HALF(HALF), .MU_W(MU_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .ratio_i, .in_valid_i, .adv_i(adv),
    .in_ready_o, .load_o(load), .emit_o(emit), .mu_o(mu)
  );

  frc_tap_window #(.DATA_W(DATA_W), .TAPS(TAPS)) u_win (
    .clk_i, .rst_ni, .load_i(load), .data_i(in_data_i), .win_o(win)
  );

  frc_subfilter_bank #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .NUM_SUB(NUM_SUB), .TAPS(TAPS),
    .VW(VW), .COEF(COEF)
  ) u_bank (
    .win_i(win), .v_o(v)
  );

  // stage 1: subfilter results and mu
  for (genvar m = 0; m < NUM_SUB; m++) begin : g_s1
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          s1_v[m] <= '0;
      else if (adv && emit) s1_v[m] <= v[m];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_mu    <= '0;
    end else if (adv) begin
      s1_valid <= emit;
      if (emit) s1_mu <= mu;
    end
  end

  frc_horner #(
    .DATA_W(DATA_W), .VW(VW), .NUM_SUB(NUM_SUB), .MU_W(MU_W),
    .MU_FRAC(RATIO_FRAC), .COEF_FRAC(COEF_FRAC)
  ) u_horner (
    .v_i(s1_v), .mu_i(s1_mu), .y_o(y)
  );

  // stage 2: rounded output
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_mu_o    <= '0;
    end else if (adv) begin
      out_valid_o <= s1_valid;
      if (s1_valid) begin
        out_data_o <= y;
        out_mu_o   <= s1_mu;
      end
    end
  end
endmodule

// File: rtl/frc_checker.sv
module frc_checker #(
  parameter int HALF       = 2,
  parameter int RATIO_FRAC = 5,
  parameter int MU_W       = RATIO_FRAC + 1,
  parameter int DATA_W     = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [RATIO_FRAC-1:0] ratio_frac_i,
  input logic                  in_valid_i,
  input logic                  in_ready_i,
  input logic                  out_valid_i,
  input logic                  out_ready_i,
  input logic [DATA_W-1:0]     out_data_i,
  input logic [MU_W-1:0]       out_mu_i
);
  localparam int CW = $clog2(HALF + 2) + 1;

  logic [CW-1:0]         in_cnt;
  logic                  prev_ok;
  logic [RATIO_FRAC-1:0] prev_mu, step_res;
  logic                  out_fire;

  assign out_fire = out_valid_i & out_ready_i;
  assign step_res = out_mu_i[RATIO_FRAC-1:0] - prev_mu - ratio_frac_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_cnt  <= '0;
      prev_ok <= 1'b0;
      prev_mu <= '0;
    end else begin
      if (in_valid_i && in_ready_i && in_cnt <= CW'(HALF)) in_cnt <= in_cnt + 1'b1;
      if (out_fire) begin
        prev_ok <= 1'b1;
        prev_mu <= out_mu_i[RATIO_FRAC-1:0];
      end
    end
  end

  // R3
  mu_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i |-> (out_mu_i[MU_W-1] == out_mu_i[MU_W-2]));

  // R8
  fill_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i |-> (in_cnt > CW'(HALF)));

  // R9
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i && !out_ready_i) |=> (out_valid_i && $stable(out_data_i) && $stable(out_mu_i)));

  // R10
  mu_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_fire && prev_ok) |-> (step_res == '0));
endmodule

bind farrow_src frc_checker #(
  .HALF((TAPS - 1) / 2), .RATIO_FRAC(RATIO_FRAC), .MU_W(RATIO_FRAC + 1), .DATA_W(DATA_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ratio_frac_i(ratio_i[RATIO_FRAC-1:0]),
  .in_valid_i(in_valid_i), .in_ready_i(in_ready_o),
  .out_valid_i(out_valid_o), .out_ready_i(out_ready_i),
  .out_data_i(out_data_o), .out_mu_i(out_mu_o)
);

// File: tb/tb_farrow_src.sv
`timescale 1ns/1ps
module tb_farrow_src;
  localparam int HALF = 2;
  localparam int NSUB = 4;
  localparam int NTAP = 5;
  localparam int SH   = 29;
  localparam int TB_COEF [NSUB][NTAP] = '{
    '{0, 0, 16384, 0, 0},
    '{0, -8192, 0, 8192, 0},
    '{0, 8192, -16384, 8192, 0},
    '{-1365, 2731, 0, -2731, 1365}
  };

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [9:0]        ratio = 10'd32;
  logic              in_valid = 1'b0;
  logic              in_ready_o;
  logic signed [15:0] in_data = '0;
  logic              out_valid_o;
  logic              out_ready = 1'b1;
  logic signed [15:0] out_data_o;
  logic signed [5:0] out_mu_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int fill_edge = 0;
  int first_edge = 0;
  bit seen_first = 1'b0;
  string tag = "R1";
  int xs [256];
  int exp_d [$];
  int exp_m [$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  farrow_src dut (
    .clk_i(clk), .rst_ni(rst_ni), .ratio_i(ratio),
    .in_valid_i(in_valid), .in_ready_o(in_ready_o), .in_data_i(in_data),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready),
    .out_data_o(out_data_o), .out_mu_o(out_mu_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int gen(input int kind, input int i);
    logic [15:0] h;
    case (kind)
      0: return (i * 1500) % 60000 - 30000;
      1: begin h = 16'((i * 7919 + 1234) * 40503); return int'($signed(h)); end
      2: return ((i / 4) % 2 == 0) ? 32767 : -32768;
      default: return ((i % 16) < 8) ? (i % 16) * 4000 - 16000 : (16 - i % 16) * 4000 - 16000;
    endcase
  endfunction

  // reference model from R2, R3, R6, R7
  task automatic build_expect(input int r, input int n);
    for (int k = 0; k < 100000; k++) begin
      longint t, c, y, term;
      int mu;
      t = longint'(k) * r;
      c = (t + 16) >>> 5;
      if (c + HALF > n - 1) break;
      mu = int'(t - c * 32);
      y = 0;
      for (int m = 0; m < NSUB; m++) begin
        longint v;
        v = 0;
        for (int j = 0; j < NTAP; j++) begin
          longint idx;
          idx = c - HALF + j;
          if (idx >= 0) v += longint'(TB_COEF[m][j]) * xs[int'(idx)];
        end
        term = v;
        for (int e = 0; e < m; e++) term *= mu;
        for (int e = 0; e < NSUB - 1 - m; e++) term *= 32;
        y += term;
      end
      y = (y + (longint'(1) <<< (SH - 1))) >>> SH;
      if (y > 32767) y = 32767;
      if (y < -32768) y = -32768;
      exp_d.push_back(int'(y));
      exp_m.push_back(mu);
    end
  endtask

  task automatic do_reset(input int r);
    @(negedge clk);
    rst_ni = 1'b0;
    ratio = 10'(r);
    in_valid = 1'b0;
    out_ready = 1'b1;
    seen_first = 1'b0;
    exp_d.delete();
    exp_m.delete();
    repeat (2) @(negedge clk);
    #1;
    chk(out_valid_o == 1'b0, "R1", "out_valid in reset", out_valid_o, 0);
    chk(in_ready_o == 1'b1, "R1", "in_ready in reset", in_ready_o, 1);
    rst_ni = 1'b1;
  endtask

  task automatic run_case(input int r, input int n, input int kind,
                          input bit bp, input string req);
    int i, waited;
    tag = req;
    do_reset(r);
    for (int k = 0; k < n; k++) xs[k] = gen(kind, k);
    build_expect(r, n);
    i = 0;
    waited = 0;
    while ((i < n || exp_d.size() != 0) && waited < 20000) begin
      @(negedge clk);
      in_valid  = (i < n);
      in_data   = (i < n) ? 16'(xs[i]) : '0;
      out_ready = bp ? (cyc % 3 != 1) : 1'b1;
      #1;
      if (in_valid && in_ready_o) begin
        if (i == HALF) fill_edge = cyc + 1;
        i++;
      end
      waited++;
    end
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    repeat (10) @(negedge clk);
    chk(exp_d.size() == 0, req, "outputs still due", exp_d.size(), 0);
    chk(i == n, req, "inputs accepted", i, n);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #2;
    if (rst_ni && out_valid_o && !seen_first) begin
      seen_first = 1'b1;
      first_edge = cyc;
    end
    if (rst_ni && out_valid_o && out_ready) begin
      if (exp_d.size() == 0) begin
        chk(1'b0, tag, "unexpected output (R4 R5 count)", out_data_o, 0);
      end else begin
        int ed, em;
        ed = exp_d.pop_front();
        em = exp_m.pop_front();
        chk(int'(out_mu_o) == em, tag, "mu (R3 R10)", out_mu_o, em);
        chk(int'(out_data_o) == ed, tag, "data (R6 R7)", out_data_o, ed);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R8 watchdog: got %0d cycles expected fewer than %0d", cyc, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R2: unity spacing, mu stays zero, output equals centre sample
    run_case(32, 20, 0, 1'b0, "R2");
    // R8: first output two edges after sample HALF is taken
    chk(first_edge == fill_edge + 2, "R8", "first output edge", first_edge, fill_edge + 2);
    // R4: 1.5 skips samples, tie at 1.5 picks sample 2 with mu -16
    run_case(48, 40, 1, 1'b0, "R4");
    // R5: 0.625 reuses sample 1
    run_case(20, 30, 1, 1'b0, "R5");
    // R9: backpressure on the output
    run_case(24, 40, 1, 1'b1, "R9");
    // R7: full-scale square wave forces saturation
    run_case(15, 24, 2, 1'b0, "R7");
    // R6: triangle at 1.25
    run_case(40, 40, 3, 1'b0, "R6");
    // R3: largest spacing
    run_case(1023, 100, 1, 1'b0, "R3");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule